// File: doc/BRIEF.md
# Bidirectional Printer Port Controller

This block is the register front end of an 8-bit parallel printer port. A host reaches it through a chip select, a 2-bit address and one-cycle read and write strobes. Through it the host latches a byte onto the data pins, or samples them when the port faces inward. It also reads the printer status lines and drives four open-drain handshake lines: strobe, auto-feed, init and select-in. The block raises an active-low interrupt from the acknowledge line. That interrupt can simply follow acknowledge, or it can hold until the host reads status.

The data-pin direction has two sources, chosen by a mode pin. With the mode pin high, one control bit sets the direction. With the mode pin low, writing the byte 0xAA or 0x55 into a select register turns the port inward or outward, and any other byte leaves the direction unchanged. Status and handshake inputs are brought into the clock domain through a parameterised synchronizer (default two stages) before they are reported. The data pins are sampled live during a port read.

The host interface has no back-pressure. A write takes effect at the clock edge on which `cpu_sel` and `cpu_wr` are both high. Read data is valid combinationally in any cycle where `cpu_sel` and `cpu_rd` are both high. A status read is consumed at the clock edge that ends its strobe cycle. No transfer ever waits.

Top module: `lpt_port_ctrl`

## Requirements
- R1: After reset the port latch reads 0x00 and the data pins are driven (`pd_oe`=1). The command register (address 2) reads 0xE0, because the cleared init bit pulls INIT low. `irq_oe` is 0.
- R2: In output mode, a write to address 0 appears on `pd_out` and reads back from address 0.
- R3: With `dir_mode`=1, control bit 5 set to 1 makes the port an input (`pd_oe`=0), and set to 0 makes it an output.
- R4: With `dir_mode`=0, an address-1 write of 0xAA selects input and 0x55 selects output. Any other value keeps the current direction, and control bit 5 has no effect.
- R5: In input mode, a port read returns the live `pd_in` value. A port write updates the latch without driving the pins, and the latched byte reaches `pd_out` once the port faces outward again.
- R6: Status (address 1) reads {BUSY, ACK, PE, SLCT, ERROR, pending_n, 1, 1} from bit 7 down to bit 0, using synchronized pin levels. pending_n is 0 when an interrupt is pending.
- R7: With `irq_latch_mode`=0, the interrupt is pending exactly while the synchronized ACK is low. `irq_n` is then 0.
- R8: With `irq_latch_mode`=1, a falling ACK sets a pending flag that stays set after ACK returns high. The flag clears at the end of a status read. If a set and a clear land on the same edge, the set wins.
- R9: Control bit 4 drives `irq_oe`. While it is 0, the interrupt output is three-stated.
- R10: Control bits 0, 1 and 3 each enable the pull-down on STROBE, AUTOFD and SLCTIN. When control bit 2 is clear, INIT is pulled low (`init_oe`=1). When it is set, INIT is released high. Only a later register write releases STROBE.
- R11: The command register reads {1,1,1, control bit 4, ~SLCTIN pin, INIT pin, ~AUTOFD pin, ~STROBE pin}, taken from the synchronized pad levels. It therefore shows a line that an outside device pulls low.
- R12: Address 3 reads 0xFF. A write to address 3 changes no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 1 | Host chip select, active high |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid while selected and reading |
| dir_mode | input | 1 | 1: control bit sets direction; 0: select-register pattern does |
| irq_latch_mode | input | 1 | 0: interrupt follows ACK; 1: latched until status read |
| pd_in | input | 8 | Data pin levels |
| pd_out | output | 8 | Data pin drive value |
| pd_oe | output | 1 | Data pin output enable |
| busy_in | input | 1 | Printer busy line |
| ack_in | input | 1 | Printer acknowledge line, active low |
| pe_in | input | 1 | Paper empty line |
| slct_in | input | 1 | Printer selected line |
| err_in | input | 1 | Printer error line |
| strobe_in | input | 1 | STROBE pad level |
| autofd_in | input | 1 | AUTOFD pad level |
| init_in | input | 1 | INIT pad level |
| slctin_in | input | 1 | SLCTIN pad level |
| strobe_oe | output | 1 | Pull STROBE low |
| autofd_oe | output | 1 | Pull AUTOFD low |
| init_oe | output | 1 | Pull INIT low |
| slctin_oe | output | 1 | Pull SLCTIN low |
| irq_n | output | 1 | Interrupt, active low |
| irq_oe | output | 1 | Interrupt output enable (0 = three-stated) |

## Verification
The direction logic is tried under both mode pin settings. The bench writes the two magic bytes, an unrelated byte and a control bit 5 that the current mode should ignore, so direction updates can be told apart from values that are only held. The data path is checked with distinct bytes on the latch and on the pins, so a read of the live pins cannot be confused with a read of the latch. Interrupt checks use an ACK pulse that ends before the status read: follow mode shows it gone, while latched mode shows it held until the read. Handshake checks combine register-driven pull-downs with a pull from an outside device, which separates the register value from the pad level.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [1:0] {
    RA_PORT  = 2'd0,
    RA_STAT  = 2'd1,
    RA_CMD   = 2'd2,
    RA_SPARE = 2'd3
  } lpt_addr_e;

  localparam logic [7:0] DIR_IN_KEY  = 8'hAA;
  localparam logic [7:0] DIR_OUT_KEY = 8'h55;
  localparam logic [7:0] CTRL_RESET  = 8'hC0;

  localparam int CB_STROBE = 0;
  localparam int CB_AUTOFD = 1;
  localparam int CB_INIT   = 2;
  localparam int CB_SLCTIN = 3;
  localparam int CB_IRQEN  = 4;
  localparam int CB_DIR    = 5;

  typedef struct packed {
    logic busy;
    logic ack;
    logic pe;
    logic slct;
    logic err;
    logic strobe;
    logic autofd;
    logic init;
    logic slctin;
  } lpt_pins_t;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  input  logic [WIDTH-1:0] rst_val,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= rst_val;
          else        chain[s] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= rst_val;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/lpt_dir_sel.sv
module lpt_dir_sel
  import lpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_mode,
  input  logic       ctrl_dir,
  input  logic       sel_wr,
  input  logic [7:0] sel_data,
  output logic       dir_in
);
  logic key_dir_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_dir_in <= 1'b0;
    end else if (sel_wr) begin
      if (sel_data == DIR_IN_KEY)       key_dir_in <= 1'b1;
      else if (sel_data == DIR_OUT_KEY) key_dir_in <= 1'b0;
    end
  end

  always_comb begin
    if (dir_mode) dir_in = ctrl_dir;
    else          dir_in = key_dir_in;
  end
endmodule

// File: rtl/lpt_irq_unit.sv
module lpt_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  input  logic latch_mode,
  input  logic stat_rd,
  output logic pending
);
  logic ack_q;
  logic held;
  logic ack_fall;

  assign ack_fall = ack_q & ~ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b1;
      held  <= 1'b0;
    end else begin
      ack_q <= ack_s;
      if (!latch_mode)   held <= 1'b0;
      else if (ack_fall) held <= 1'b1;
      else if (stat_rd)  held <= 1'b0;
    end
  end

  always_comb begin
    if (latch_mode) pending = held;
    else            pending = ~ack_s;
  end
endmodule

// File: rtl/lpt_port_ctrl.sv
module lpt_port_ctrl
  import lpt_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dir_mode,
  input  logic          irq_latch_mode,
  input  logic [DW-1:0] pd_in,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  input  logic          busy_in,
  input  logic          ack_in,
  input  logic          pe_in,
  input  logic          slct_in,
  input  logic          err_in,
  input  logic          strobe_in,
  input  logic          autofd_in,
  input  logic          init_in,
  input  logic          slctin_in,
  output logic          strobe_oe,
  output logic          autofd_oe,
  output logic          init_oe,
  output logic          slctin_oe,
  output logic          irq_n,
  output logic          irq_oe
);
  localparam int PW = $bits(lpt_pins_t);

  lpt_addr_e addr;
  logic      wr_port, wr_sel, wr_ctrl, rd_stat;
  logic [DW-1:0] port_q;
  logic [7:0]    ctrl_q;
  logic          dir_in, pending;
  lpt_pins_t     raw, syn, raw_rst;

  assign addr    = lpt_addr_e'(cpu_addr);
  assign wr_port = cpu_sel & cpu_wr & (addr == RA_PORT);
  assign wr_sel  = cpu_sel & cpu_wr & (addr == RA_STAT);
  assign wr_ctrl = cpu_sel & cpu_wr & (addr == RA_CMD);
  assign rd_stat = cpu_sel & cpu_rd & (addr == RA_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      ctrl_q <= CTRL_RESET;
    end else begin
      if (wr_port) port_q <= cpu_wdata;
      if (wr_ctrl) ctrl_q <= cpu_wdata[7:0];
    end
  end

  always_comb begin
    raw = '{busy: busy_in, ack: ack_in, pe: pe_in, slct: slct_in, err: err_in,
            strobe: strobe_in, autofd: autofd_in, init: init_in, slctin: slctin_in};
    raw_rst = '{busy: 1'b0, ack: 1'b1, pe: 1'b0, slct: 1'b0, err: 1'b0,
                strobe: 1'b1, autofd: 1'b1, init: 1'b0, slctin: 1'b1};
  end

  lpt_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_in    (raw),
    .rst_val (raw_rst),
    .q_out   (syn)
  );

  lpt_dir_sel u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_mode (dir_mode),
    .ctrl_dir (ctrl_q[CB_DIR]),
    .sel_wr   (wr_sel),
    .sel_data (cpu_wdata[7:0]),
    .dir_in   (dir_in)
  );

  lpt_irq_unit u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_s      (syn.ack),
    .latch_mode (irq_latch_mode),
    .stat_rd    (rd_stat),
    .pending    (pending)
  );

  assign pd_out    = port_q;
  assign pd_oe     = ~dir_in;
  assign strobe_oe = ctrl_q[CB_STROBE];
  assign autofd_oe = ctrl_q[CB_AUTOFD];
  assign init_oe   = ~ctrl_q[CB_INIT];
  assign slctin_oe = ctrl_q[CB_SLCTIN];
  assign irq_n     = ~pending;
  assign irq_oe    = ctrl_q[CB_IRQEN];

  always_comb begin
    cpu_rdata = '1;
    if (cpu_sel && cpu_rd) begin
      unique case (addr)
        RA_PORT:  cpu_rdata = dir_in ? pd_in : port_q;
        RA_STAT:  cpu_rdata = DW'({syn.busy, syn.ack, syn.pe, syn.slct, syn.err,
                                  ~pending, 2'b11});
        RA_CMD:   cpu_rdata = DW'({3'b111, ctrl_q[CB_IRQEN], ~syn.slctin,
                                  syn.init, ~syn.autofd, ~syn.strobe});
        RA_SPARE: cpu_rdata = '1;
      endcase
    end
  end
endmodule

// File: rtl/lpt_port_ctrl_chk.sv
module lpt_port_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_sel,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic [1:0]    cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          dir_mode,
  input logic          pd_oe,
  input logic          strobe_oe,
  input logic          irq_oe
);
  // R9
  irq_enable_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_wr && cpu_addr == 2'd2) |=> (irq_oe == $past(cpu_wdata[4])));

  // R3
  ctrl_dir_sets_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_wr && cpu_addr == 2'd2 && dir_mode)
      |=> (!dir_mode || pd_oe == !$past(cpu_wdata[5])));

  // R4
  key_in_sets_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_wr && cpu_addr == 2'd1 && !dir_mode && cpu_wdata[7:0] == 8'hAA)
      |=> (dir_mode || !pd_oe));

  // R10
  strobe_pull_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_wr && cpu_addr == 2'd2) |=> (strobe_oe == $past(cpu_wdata[0])));

  // R12
  spare_reads_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && cpu_rd && cpu_addr == 2'd3) |-> (cpu_rdata == '1));
endmodule

bind lpt_port_ctrl lpt_port_ctrl_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_sel   (cpu_sel),
  .cpu_rd    (cpu_rd),
  .cpu_wr    (cpu_wr),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_rdata (cpu_rdata),
  .dir_mode  (dir_mode),
  .pd_oe     (pd_oe),
  .strobe_oe (strobe_oe),
  .irq_oe    (irq_oe)
);

// File: tb/tb_lpt_port_ctrl.sv
`timescale 1ns/1ps
module tb_lpt_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cpu_sel = 0, cpu_rd = 0, cpu_wr = 0;
  logic [1:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic dir_mode = 1, irq_latch_mode = 0;
  logic [7:0] pd_out, pd_pad, ext_pd = 8'h00;
  logic pd_oe;
  logic busy = 0, ack = 1, pe = 0, slct = 0, err = 0;
  logic strobe_oe, autofd_oe, init_oe, slctin_oe, irq_n, irq_oe;
  logic ext_autofd_low = 0;
  logic strobe_pad, autofd_pad, init_pad, slctin_pad;

  assign pd_pad     = pd_oe ? pd_out : ext_pd;
  assign strobe_pad = ~strobe_oe;
  assign autofd_pad = ~(autofd_oe | ext_autofd_low);
  assign init_pad   = ~init_oe;
  assign slctin_pad = ~slctin_oe;

  lpt_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dir_mode(dir_mode), .irq_latch_mode(irq_latch_mode),
    .pd_in(pd_pad), .pd_out(pd_out), .pd_oe(pd_oe),
    .busy_in(busy), .ack_in(ack), .pe_in(pe), .slct_in(slct), .err_in(err),
    .strobe_in(strobe_pad), .autofd_in(autofd_pad), .init_in(init_pad), .slctin_in(slctin_pad),
    .strobe_oe(strobe_oe), .autofd_oe(autofd_oe), .init_oe(init_oe), .slctin_oe(slctin_oe),
    .irq_n(irq_n), .irq_oe(irq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read strobe
  always @(negedge clk) begin
    if (cpu_sel && cpu_rd) begin
      if (exp_q.size() == 0) check("read without expectation", cpu_rdata, 8'hxx);
      else check(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    cpu_sel = 1; cpu_rd = 1; cpu_addr = a;
    @(posedge clk); #1;
    cpu_sel = 0; cpu_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(4);
    // R1 reset state
    check("R1 pd_oe", {7'd0, pd_oe}, 8'h01);
    check("R1 irq_oe (R9)", {7'd0, irq_oe}, 8'h00);
    check("R1 init_oe (R10)", {7'd0, init_oe}, 8'h01);
    rd(2'd2, 8'hE0, "R1 command after reset");
    rd(2'd0, 8'h00, "R1 port after reset");
    // R2 output mode write
    wr(2'd0, 8'hA5);
    check("R2 pd_out", pd_out, 8'hA5);
    rd(2'd0, 8'hA5, "R2 port readback");
    wr(2'd0, 8'h3C);
    rd(2'd0, 8'h3C, "R2 port readback 2");
    // R3 control-bit direction
    dir_mode = 1;
    wr(2'd2, 8'h24);
    check("R3 input via ctrl5", {7'd0, pd_oe}, 8'h00);
    // R5 input mode
    ext_pd = 8'h5A;
    rd(2'd0, 8'h5A, "R5 live pins");
    wr(2'd0, 8'h77);
    check("R5 pins not driven", {7'd0, pd_oe}, 8'h00);
    rd(2'd0, 8'h5A, "R5 still live after write");
    wr(2'd2, 8'h04);
    check("R3 output via ctrl5", {7'd0, pd_oe}, 8'h01);
    check("R5 latched byte driven", pd_out, 8'h77);
    // R4 select-register direction
    dir_mode = 0;
    wr(2'd1, 8'hAA);
    check("R4 0xAA input", {7'd0, pd_oe}, 8'h00);
    wr(2'd1, 8'h12);
    check("R4 other value holds", {7'd0, pd_oe}, 8'h00);
    wr(2'd1, 8'h55);
    check("R4 0x55 output", {7'd0, pd_oe}, 8'h01);
    wr(2'd2, 8'h24);
    check("R4 ctrl5 ignored", {7'd0, pd_oe}, 8'h01);
    wr(2'd2, 8'h04);
    // R6 status layout
    busy = 1; ack = 1; pe = 0; slct = 1; err = 0; idle(4);
    rd(2'd1, 8'hD7, "R6 status pattern 1");
    busy = 0; pe = 1; err = 1; idle(4);
    rd(2'd1, 8'h7F, "R6 status pattern 2");
    // R7 follow mode
    wr(2'd2, 8'h14);
    check("R9 irq_oe enabled", {7'd0, irq_oe}, 8'h01);
    ack = 0; idle(4);
    check("R7 irq_n low", {7'd0, irq_n}, 8'h00);
    rd(2'd1, 8'h3B, "R7 status pending");
    ack = 1; idle(4);
    check("R7 irq_n follows high", {7'd0, irq_n}, 8'h01);
    wr(2'd2, 8'h04);
    check("R9 irq three-stated", {7'd0, irq_oe}, 8'h00);
    // R8 latched mode
    irq_latch_mode = 1;
    wr(2'd2, 8'h14);
    ack = 0; idle(3); ack = 1; idle(5);
    check("R8 held after ack high", {7'd0, irq_n}, 8'h00);
    rd(2'd1, 8'h7B, "R8 status shows held");
    idle(1);
    check("R8 cleared by status read", {7'd0, irq_n}, 8'h01);
    rd(2'd1, 8'h7F, "R8 status after clear");
    irq_latch_mode = 0;
    // R10 / R11 handshake lines
    wr(2'd2, 8'h0B);
    check("R10 pulls", {4'd0, slctin_oe, init_oe, autofd_oe, strobe_oe}, 8'h0F);
    idle(4);
    rd(2'd2, 8'hEB, "R11 command readback");
    idle(6);
    check("R10 strobe stays asserted", {7'd0, strobe_oe}, 8'h01);
    wr(2'd2, 8'h04);
    check("R10 released", {4'd0, slctin_oe, init_oe, autofd_oe, strobe_oe}, 8'h00);
    idle(4);
    rd(2'd2, 8'hE4, "R11 command released");
    ext_autofd_low = 1; idle(4);
    rd(2'd2, 8'hE6, "R11 outside pull seen");
    ext_autofd_low = 0;
    // R12 spare address
    rd(2'd3, 8'hFF, "R12 spare reads ones");
    wr(2'd3, 8'h00);
    rd(2'd0, 8'h77, "R12 port unchanged");
    idle(4);
    rd(2'd2, 8'hE4, "R12 control unchanged");
    check("R12 direction unchanged", {7'd0, pd_oe}, 8'h01);
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule